// File: doc/BRIEF.md
# Pipelined Tower-Field Byte Inverter

This block computes the multiplicative inverse of an 8-bit element of the composite field GF(((2^2)^2)^2). It is the nonlinear core of an AES-style byte substitution. The basis change into the tower field, the change back out of it and the affine step all sit outside this block. The input byte is split into a high nibble `a1` and a low nibble `a0`, read as `a1*z + a0`.

Each nibble is an element `h*y + l` of GF(16), with `h` in bits [3:2] and `l` in bits [1:0]. Each 2-bit piece is an element `u*w + v` of GF(4), with `u` in the upper bit. The field tower is built as follows:

- GF(4) uses w^2 = w + 1.
- GF(16) uses y^2 = y + w. The constant w is encoded as 2'b10.
- The top level uses z^2 = z + LAMBDA.

The inverse is found through the norm `D = LAMBDA*a1^2 + a0*a1 + a0^2`. The result is then `(a1*D^-1)*z + (a0+a1)*D^-1`. The 4-bit inverse of D uses the same construction one level down, on 2-bit halves. The work is split over five register stages:

1. The products and squares.
2. The first sum and the constant multiply.
3. The norm.
4. The 4-bit inverse.
5. The two output products.

The block accepts one byte per clock with a valid flag. The result and its flag appear a fixed five cycles later.

Top module: `gf256_tower_inv`

## Requirements
- R1: A byte presented with `in_valid` high before clock edge k appears on `out_byte`, with `out_valid` high, right after edge k+4. That is five register stages of latency.
- R2: For every nonzero input X, the output Y satisfies X*Y = 1 in the tower field defined above. The byte layout and encodings are the ones given in the description. Products use z^2 = z + LAMBDA, y^2 = y + 2'b10 and w^2 = w + 1.
- R3: An input of 8'h00 produces an output of 8'h00.
- R4: A synchronous active-high `rst` clears every valid bit in the pipeline. `out_valid` is low after any clock edge at which `rst` was high. No input that entered before the reset ever produces an `out_valid` pulse.
- R5: Inputs may arrive on every consecutive cycle with no bubbles, and each one produces its own correct result in order.
- R6: A cycle with `in_valid` low produces `out_valid` low five edges later, whatever value `in_byte` carries.
- R7: The parameter LAMBDA (4 bits, default 4'b1100) selects the top-level constant. An instance built with LAMBDA = 4'b1000 satisfies R2 under that constant. Under that constant, 8'h10 maps to 8'hAA, while the default constant maps 8'h10 to 8'h55.
- R8: Under the default constant, these exact pairs hold:

  | Input | Output |
  |-------|--------|
  | 8'h01 | 8'h01 |
  | 8'h02 | 8'h03 |
  | 8'h03 | 8'h02 |
  | 8'h04 | 8'h0F |
  | 8'h0F | 8'h04 |

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Marks `in_byte` as a live operand this cycle |
| in_byte | input | 8 | Operand: high nibble a1, low nibble a0 |
| out_valid | output | 1 | Marks `out_byte` as a live result |
| out_byte | output | 8 | Inverse of the operand accepted five cycles earlier |

## Verification
The bench streams all 256 bytes back to back through two instances that use different constants. It checks every result by multiplying it back against the operand in an independent tower-field model, so a wrong reduction constant at any level shows up as a product other than one. The zero byte and the subfield elements are checked against exact values: a design that left the inverse of zero undefined, or mixed up the nibble order, returns a nonzero or swapped byte there. Gapped traffic and a reset in mid-stream catch a valid flag that is misaligned with the data, one that leaks through reset, or operands from neighbouring inputs mixed inside a stage.

// File: rtl/gf256_tower_inv.sv
module gf256_tower_inv #(
  parameter logic [3:0] LAMBDA = 4'b1100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       out_valid,
  output logic [7:0] out_byte
);

  // GF(4): w^2 = w + 1
  function automatic logic [1:0] g4_mul(input logic [1:0] a, input logic [1:0] b);
    logic hh;
    hh = a[1] & b[1];
    return {hh ^ (a[1] & b[0]) ^ (a[0] & b[1]), hh ^ (a[0] & b[0])};
  endfunction

  function automatic logic [1:0] g4_sq(input logic [1:0] a);
    return {a[1], a[1] ^ a[0]};
  endfunction

  // x^-1 = x^2 in GF(4); zero maps to zero
  function automatic logic [1:0] g4_inv(input logic [1:0] a);
    return g4_sq(a);
  endfunction

  // multiply by w (2'b10)
  function automatic logic [1:0] g4_phi(input logic [1:0] a);
    return {a[1] ^ a[0], a[1]};
  endfunction

  // GF(16): y^2 = y + w
  function automatic logic [3:0] g16_mul(input logic [3:0] a, input logic [3:0] b);
    logic [1:0] lo_p, hi_p, mid_p;
    lo_p  = g4_mul(a[1:0], b[1:0]);
    hi_p  = g4_mul(a[3:2], b[3:2]);
    mid_p = g4_mul(a[3:2] ^ a[1:0], b[3:2] ^ b[1:0]);
    return {mid_p ^ lo_p, lo_p ^ g4_phi(hi_p)};
  endfunction

  function automatic logic [3:0] g16_sq(input logic [3:0] a);
    logic [1:0] h2;
    h2 = g4_sq(a[3:2]);
    return {h2, g4_phi(h2) ^ g4_sq(a[1:0])};
  endfunction

  function automatic logic [3:0] g16_inv(input logic [3:0] d);
    logic [1:0] e, ei;
    e  = g4_phi(g4_sq(d[3:2])) ^ g4_mul(d[3:2], d[1:0]) ^ g4_sq(d[1:0]);
    ei = g4_inv(e);
    return {g4_mul(d[3:2], ei), g4_mul(d[3:2] ^ d[1:0], ei)};
  endfunction

  logic [3:0] a1, a0;
  assign a1 = in_byte[7:4];
  assign a0 = in_byte[3:0];

  logic       s1_v, s2_v, s3_v, s4_v, s5_v;
  logic [3:0] s1_p01, s1_sq0, s1_sq1, s1_a1, s1_s;
  logic [3:0] s2_t, s2_c, s2_a1, s2_s;
  logic [3:0] s3_delta, s3_a1, s3_s;
  logic [3:0] s4_dinv, s4_a1, s4_s;
  logic [3:0] s5_hi, s5_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
      s3_v <= 1'b0;
      s4_v <= 1'b0;
      s5_v <= 1'b0;
    end else begin
      s1_v <= in_valid;
      s2_v <= s1_v;
      s3_v <= s2_v;
      s4_v <= s3_v;
      s5_v <= s4_v;
    end
  end

  always_ff @(posedge clk) begin
    // stage 1: products and squares
    s1_p01   <= g16_mul(a0, a1);
    s1_sq0   <= g16_sq(a0);
    s1_sq1   <= g16_sq(a1);
    s1_a1    <= a1;
    s1_s     <= a0 ^ a1;
    // stage 2: first sum and constant multiply
    s2_t     <= s1_p01 ^ s1_sq0;
    s2_c     <= g16_mul(LAMBDA, s1_sq1);
    s2_a1    <= s1_a1;
    s2_s     <= s1_s;
    // stage 3: norm
    s3_delta <= s2_t ^ s2_c;
    s3_a1    <= s2_a1;
    s3_s     <= s2_s;
    // stage 4: 4-bit inverse
    s4_dinv  <= g16_inv(s3_delta);
    s4_a1    <= s3_a1;
    s4_s     <= s3_s;
    // stage 5: output products
    s5_hi    <= g16_mul(s4_a1, s4_dinv);
    s5_lo    <= g16_mul(s4_s, s4_dinv);
  end

  assign out_valid = s5_v;
  assign out_byte  = {s5_hi, s5_lo};

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> !out_valid); // R4
  AST_NORM_NONZERO: assert property (@(posedge clk) disable iff (rst) (s3_v && (s3_a1 | s3_s) != 4'd0) |-> s3_delta != 4'd0); // R2
  AST_ZERO_NORM_ZERO_INV: assert property (@(posedge clk) disable iff (rst) (s3_v && s3_delta == 4'd0) |=> s4_dinv == 4'd0); // R3
  AST_INV_NONZERO: assert property (@(posedge clk) disable iff (rst) (s3_v && s3_delta != 4'd0) |=> s4_dinv != 4'd0); // R2
  AST_OUT_NONZERO: assert property (@(posedge clk) disable iff (rst) (s4_v && (s4_a1 | s4_s) != 4'd0) |=> out_byte != 8'd0); // R2

endmodule

// File: tb/tb_gf256_tower_inv.sv
module tb_gf256_tower_inv;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       out_valid, out2_valid;
  logic [7:0] out_byte, out2_byte;

  always #5 clk = ~clk;

  gf256_tower_inv dut (.clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
                       .out_valid(out_valid), .out_byte(out_byte));
  gf256_tower_inv #(.LAMBDA(4'b1000)) dut2 (.clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
                       .out_valid(out2_valid), .out_byte(out2_byte));

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit rst_q  = 1'b1;
  bit done   = 1'b0;

  logic [7:0] q_in[$];
  int         q_cyc[$];
  logic [8:0] q_e1[$];
  logic [8:0] q_e2[$];

  // {input, expected default, expected LAMBDA=4'b1000}
  localparam logic [23:0] VEC [7] = '{
    24'h00_00_00, 24'h01_01_01, 24'h02_03_03, 24'h03_02_02,
    24'h04_0F_0F, 24'h0F_04_04, 24'h10_55_AA
  };

  // independent tower multiply model, written from the field definitions
  function automatic logic [1:0] m4(input logic [1:0] a, input logic [1:0] b);
    logic c2, c1, c0;
    c2 = a[1] & b[1];
    c1 = (a[1] & b[0]) ^ (a[0] & b[1]);
    c0 = a[0] & b[0];
    return {c1 ^ c2, c0 ^ c2};
  endfunction

  function automatic logic [3:0] m16(input logic [3:0] a, input logic [3:0] b);
    logic [1:0] c2, c1, c0;
    c2 = m4(a[3:2], b[3:2]);
    c1 = m4(a[3:2], b[1:0]) ^ m4(a[1:0], b[3:2]);
    c0 = m4(a[1:0], b[1:0]);
    return {c1 ^ c2, c0 ^ m4(2'b10, c2)};
  endfunction

  function automatic logic [7:0] m256(input logic [7:0] a, input logic [7:0] b, input logic [3:0] lam);
    logic [3:0] c2, c1, c0;
    c2 = m16(a[7:4], b[7:4]);
    c1 = m16(a[7:4], b[3:0]) ^ m16(a[3:0], b[7:4]);
    c0 = m16(a[3:0], b[3:0]);
    return {c1 ^ c2, c0 ^ m16(lam, c2)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc   <= cyc + 1;
    rst_q <= rst;
  end

  // output checker, samples on the falling edge
  always @(negedge clk) begin
    if (rst_q) begin
      check(!out_valid && !out2_valid, "R4 valid cleared by reset", {7'd0, out_valid}, 8'd0);
      q_in.delete(); q_cyc.delete(); q_e1.delete(); q_e2.delete();
    end else begin
      bit due;
      due = (q_cyc.size() > 0) && (q_cyc[0] == cyc - 5);
      check(out_valid == due && out2_valid == due, "R1/R6 valid timing",
            {7'd0, out_valid}, {7'd0, due});
      if (due) begin
        logic [7:0] x;
        logic [8:0] e1, e2;
        x  = q_in.pop_front();
        e1 = q_e1.pop_front();
        e2 = q_e2.pop_front();
        void'(q_cyc.pop_front());
        if (x == 8'h00) begin
          check(out_byte == 8'h00, "R3 zero maps to zero", out_byte, 8'h00);
          check(out2_byte == 8'h00, "R3 zero maps to zero (alt)", out2_byte, 8'h00);
        end else begin
          check(m256(x, out_byte, 4'b1100) == 8'h01, "R2 product is one",
                m256(x, out_byte, 4'b1100), 8'h01);
          check(m256(x, out2_byte, 4'b1000) == 8'h01, "R7 product is one (alt)",
                m256(x, out2_byte, 4'b1000), 8'h01);
        end
        if (e1[8]) check(out_byte == e1[7:0], "R8 exact value", out_byte, e1[7:0]);
        if (e2[8]) check(out2_byte == e2[7:0], "R7 exact value (alt)", out2_byte, e2[7:0]);
      end
    end
  end

  task automatic send(input bit v, input logic [7:0] b, input logic [8:0] e1, input logic [8:0] e2);
    @(posedge clk);
    #1;
    in_valid = v;
    in_byte  = b;
    if (v && !rst) begin
      q_in.push_back(b);
      q_cyc.push_back(cyc);
      q_e1.push_back(e1);
      q_e2.push_back(e2);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) send(1'b0, 8'hC3, 9'd0, 9'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // table of known pairs, back to back (R8, R7, R3)
    for (int i = 0; i < 7; i++)
      send(1'b1, VEC[i][23:16], {1'b1, VEC[i][15:8]}, {1'b1, VEC[i][7:0]});
    idle(6);

    // all 256 inputs with no bubbles (R5, R2)
    for (int i = 0; i < 256; i++) send(1'b1, 8'(i), 9'd0, 9'd0);
    idle(6);

    // gapped traffic with garbage on idle cycles (R6, R1)
    for (int i = 0; i < 48; i++) begin
      if (i % 3 == 1) send(1'b0, 8'(i * 37 + 5), 9'd0, 9'd0);
      else            send(1'b1, 8'(i * 7 + 3), 9'd0, 9'd0);
    end
    idle(6);

    // reset in the middle of a burst (R4)
    for (int i = 0; i < 4; i++) send(1'b1, 8'(8'h80 + i), 9'd0, 9'd0);
    @(posedge clk);
    #1 rst = 1'b1; in_valid = 1'b1; in_byte = 8'h77;
    @(posedge clk);
    #1 rst = 1'b0; in_valid = 1'b0;
    idle(8);

    // traffic resumes after reset
    send(1'b1, 8'h10, {1'b1, 8'h55}, {1'b1, 8'hAA});
    send(1'b1, 8'h00, {1'b1, 8'h00}, {1'b1, 8'h00});
    send(1'b1, 8'hFF, 9'd0, 9'd0);
    idle(8);

    check(q_in.size() == 0, "R1 every input produced a result", 8'(q_in.size()), 8'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule